// File: doc/BRIEF.md
# Mixed Page-Size Translation Cache with Table Walker

This block translates 43-bit virtual addresses to physical addresses through a small fully associative cache of translations. Each slot holds either a 4 KB mapping or a 2 MB mapping, together with a bit that records which. A 2 MB slot compares only the upper virtual address bits, so one slot covers a whole 2 MB region.

When a lookup misses, a hardware engine walks a three-level table in memory, starting from a root base address. Each table entry is 8 bytes. At the second level an entry can end the walk early and map a 2 MB page directly. The result is written into the cache in first-in/first-out order and returned to the requester. An entry without its valid bit at any level ends the walk with a fault response, and nothing is installed.

The requester presents an address with a valid strobe while the block is not busy. Results come back on a response strobe that carries a hit flag, a fault flag and the physical address. Table reads go out on a simple request/valid memory port.

Top module: `mpt_xlate`

## Requirements
- R1: After reset, `busy`, `resp_valid` and `mem_rd_req` are low and every slot is empty, so the first lookup starts a walk.
- R2: A lookup that matches a 4 KB slot is answered in the cycle after it is accepted. The answer has `resp_hit`=1 and `resp_pa` = {stored frame, va[11:0]}, and no memory read is made.
- R3: A 2 MB slot matches on va[42:21] alone and answers with `resp_pa` = {frame bits PA_W-1:21, va[20:0]}. An address in the neighbouring 2 MB region does not match it.
- R4: The walk reads level 1 at root + va[42:32]*8. It reads level 2 at B1 + va[31:21]*8 and level 3 at B2 + va[20:12]*8, where Bn is the previous entry's bits PA_W-1:12 with twelve zero bits appended.
- R5: Entry layout: bit 0 is valid and bit 1 is the leaf flag. The leaf flag is honoured only at level 2 and is ignored at level 3. Bits PA_W-1:12 hold the next table base or the 4 KB frame. A level-2 leaf takes its 2 MB frame from bits PA_W-1:21.
- R6: A 4 KB miss makes exactly three reads and a 2 MB miss makes two. The answer (`resp_hit`=0, translated `resp_pa`) is given in the cycle after the last read data is taken, and the mapping is installed.
- R7: An entry with bit 0 clear at any level ends the walk after that read with a one-cycle `resp_fault`. Nothing is installed, so the same address walks again.
- R8: Fills go to the slot under a write pointer. The pointer advances by one, wrapping after the last slot, only on a fill. The oldest fill is replaced first, however recently it was hit.
- R9: `busy` is high from the cycle after a missing lookup is accepted until its answer. Lookups presented while busy are ignored and produce no answer.
- R10: `mem_rd_req` stays high with a stable `mem_rd_addr` until `mem_rd_valid` is seen; read data is taken in the cycle `mem_rd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 43 | Virtual address to translate |
| root_base | input | PA_W | Physical base of the level-1 table |
| mem_rd_req | output | 1 | Table read request |
| mem_rd_addr | output | PA_W | Table entry address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Table entry read from memory |
| resp_valid | output | 1 | Answer strobe |
| resp_hit | output | 1 | Answer came from the cache |
| resp_fault | output | 1 | Walk found an invalid entry |
| resp_pa | output | PA_W | Translated physical address |
| busy | output | 1 | Walk in progress; lookups ignored |

## Verification
A cache hit answers one cycle after the accepting clock edge. A walk answers one cycle after the edge that takes its final read. Each read completes lat+1 cycles after it is requested, where lat is the bench memory's programmable latency. The scoreboard monitor samples `resp_valid` on falling edges and pops the next expected item, so every answer is checked in the cycle it appears. Any answer with an empty queue, such as one raised by a lookup made while busy, is reported. Read handshakes are logged on the falling edge before the edge that completes them, so walk addresses and read counts are compared per lookup.

// File: rtl/mpt_pkg.sv
// Shared constants and types for the mixed page-size translation block.
// Assumes a fixed 43-bit virtual address split 11/11/9/12 and 8-byte entries.
package mpt_pkg;
    localparam int VA_W       = 43;
    localparam int PTE_W      = 64;
    localparam int PG_SHIFT   = 12;             // 4 KB page offset bits
    localparam int HUGE_SHIFT = 21;             // 2 MB page offset bits
    localparam int VPN_W      = VA_W - PG_SHIFT;
    localparam int HVPN_W     = VA_W - HUGE_SHIFT;
    localparam int SUB_W      = HUGE_SHIFT - PG_SHIFT;  // 4 KB pages per 2 MB
    localparam int PTE_SHIFT  = 3;              // log2 of entry size in bytes
    localparam int BIT_VALID  = 0;
    localparam int BIT_LEAF   = 1;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_LV1  = 2'd1,
        WS_LV2  = 2'd2,
        WS_LV3  = 2'd3
    } walk_state_e;
endpackage

// File: rtl/mpt_tlb_array.sv
// Fully associative translation store with per-slot page size.
// Each slot matches va[42:12] (4 KB) or va[42:21] (2 MB); the lowest matching
// index wins. Fills go to a FIFO write pointer that moves only on a fill.
// Assumes the walker never installs overlapping mappings.
module mpt_tlb_array
    import mpt_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int PA_W    = 40,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int PFN_W  = PA_W - PG_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VA_W-1:0]  lk_va,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_pa,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic             fill_huge,
    input  logic [PFN_W-1:0] fill_pfn
);
    logic             slot_v    [ENTRIES];
    logic             slot_huge [ENTRIES];
    logic [VPN_W-1:0] slot_vpn  [ENTRIES];
    logic [PFN_W-1:0] slot_pfn  [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic [IDX_W-1:0]   wr_ptr;
    logic [PFN_W-1:0]   sel_pfn;
    logic               sel_huge;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        // Size-dependent tag compare for one slot.
        assign hit_vec[g] = slot_v[g] &&
            (slot_huge[g] ? (slot_vpn[g][VPN_W-1:SUB_W] == lk_va[VA_W-1:HUGE_SHIFT])
                          : (slot_vpn[g] == lk_va[VA_W-1:PG_SHIFT]));

        // Slot storage: cleared by reset, written when the pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_v[g]    <= 1'b0;
                slot_huge[g] <= 1'b0;
                slot_vpn[g]  <= '0;
                slot_pfn[g]  <= '0;
            end else if (fill_en && (wr_ptr == IDX_W'(g))) begin
                slot_v[g]    <= 1'b1;
                slot_huge[g] <= fill_huge;
                slot_vpn[g]  <= fill_vpn;
                slot_pfn[g]  <= fill_pfn;
            end
        end
    end

    // FIFO write pointer: steps and wraps on each fill only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_ptr <= '0;
        else if (fill_en)
            wr_ptr <= (wr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : wr_ptr + 1'b1;
    end

    // Pick the lowest matching slot's frame and size.
    always_comb begin
        sel_pfn  = '0;
        sel_huge = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_pfn  = slot_pfn[i];
                sel_huge = slot_huge[i];
            end
        end
    end

    // Merge frame and offset according to page size.
    assign lk_hit = |hit_vec;
    assign lk_pa  = sel_huge ? {sel_pfn[PFN_W-1:SUB_W], lk_va[HUGE_SHIFT-1:0]}
                             : {sel_pfn, lk_va[PG_SHIFT-1:0]};

    // R8: walker installs only on a miss, so no address ever matches two slots.
    a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    // R8: replacement pointer holds when no fill happens.
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |=> $stable(wr_ptr));
endmodule

// File: rtl/mpt_walker.sv
// Three-level table walker. Reads one 8-byte entry per level over a
// request/valid port, ends early at a level-2 leaf (2 MB), faults on an
// invalid entry, and emits a one-cycle fill plus a registered answer.
// Assumes root_base and read data stay meaningful for the whole walk.
module mpt_walker
    import mpt_pkg::*;
#(
    parameter int PA_W   = 40,
    localparam int PFN_W = PA_W - PG_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VA_W-1:0]  start_va,
    input  logic [PA_W-1:0]  root_base,
    output logic             mem_rd_req,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [PTE_W-1:0] mem_rd_data,
    output logic             busy,
    output logic             fill_en,
    output logic [VPN_W-1:0] fill_vpn,
    output logic             fill_huge,
    output logic [PFN_W-1:0] fill_pfn,
    output logic             done,
    output logic             fault,
    output logic [PA_W-1:0]  done_pa
);
    walk_state_e     state_q;
    logic [VA_W-1:0] va_q;
    logic [PA_W-1:0] addr_q;
    logic            done_q;
    logic            fault_q;
    logic [PA_W-1:0] pa_q;
    logic            take;
    logic            pte_ok;
    logic            pte_leaf;
    logic [PA_W-1:0] next_base;
    logic            unused_pte_bits;

    assign take      = (state_q != WS_IDLE) && mem_rd_valid;
    assign pte_ok    = mem_rd_data[BIT_VALID];
    assign pte_leaf  = mem_rd_data[BIT_LEAF];
    assign next_base = {mem_rd_data[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
    assign unused_pte_bits = ^{mem_rd_data[PTE_W-1:PA_W], mem_rd_data[PG_SHIFT-1:2]};

    // Fill strobe: valid leaf taken at level 2 (huge) or level 3 (4 KB).
    always_comb begin
        fill_en   = 1'b0;
        fill_huge = 1'b0;
        fill_pfn  = mem_rd_data[PA_W-1:PG_SHIFT];
        if (take && pte_ok) begin
            if (state_q == WS_LV2 && pte_leaf) begin
                fill_en   = 1'b1;
                fill_huge = 1'b1;
                fill_pfn  = {mem_rd_data[PA_W-1:HUGE_SHIFT], {SUB_W{1'b0}}};
            end else if (state_q == WS_LV3) begin
                fill_en   = 1'b1;
            end
        end
    end

    // Walk sequencer: address generation per level and answer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            va_q    <= '0;
            addr_q  <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            pa_q    <= '0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            case (state_q)
                WS_IDLE: begin
                    if (start) begin
                        va_q    <= start_va;
                        addr_q  <= root_base + (PA_W'(start_va[42:32]) << PTE_SHIFT);
                        state_q <= WS_LV1;
                    end
                end
                WS_LV1: begin
                    if (mem_rd_valid) begin
                        if (!pte_ok) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b1;
                            pa_q    <= '0;
                            state_q <= WS_IDLE;
                        end else begin
                            addr_q  <= next_base + (PA_W'(va_q[31:21]) << PTE_SHIFT);
                            state_q <= WS_LV2;
                        end
                    end
                end
                WS_LV2: begin
                    if (mem_rd_valid) begin
                        if (!pte_ok) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b1;
                            pa_q    <= '0;
                            state_q <= WS_IDLE;
                        end else if (pte_leaf) begin
                            done_q  <= 1'b1;
                            pa_q    <= {mem_rd_data[PA_W-1:HUGE_SHIFT], va_q[HUGE_SHIFT-1:0]};
                            state_q <= WS_IDLE;
                        end else begin
                            addr_q  <= next_base + (PA_W'(va_q[20:12]) << PTE_SHIFT);
                            state_q <= WS_LV3;
                        end
                    end
                end
                WS_LV3: begin
                    if (mem_rd_valid) begin
                        done_q  <= 1'b1;
                        fault_q <= !pte_ok;
                        pa_q    <= pte_ok ? {mem_rd_data[PA_W-1:PG_SHIFT], va_q[PG_SHIFT-1:0]} : '0;
                        state_q <= WS_IDLE;
                    end
                end
                default: state_q <= WS_IDLE;
            endcase
        end
    end

    assign busy        = (state_q != WS_IDLE);
    assign mem_rd_req  = busy;
    assign mem_rd_addr = addr_q;
    assign fill_vpn    = va_q[VA_W-1:PG_SHIFT];
    assign done        = done_q;
    assign fault       = fault_q;
    assign done_pa     = pa_q;

    // R10: an unanswered read keeps its request and address.
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
    // R7: a fault answer never accompanies an install.
    a_r7_fault_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !$past(fill_en));
    // R6: an install is answered next cycle without fault.
    a_r6_fill_answers: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (done && !fault));
    // R6: walk answers are single-cycle pulses.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/mpt_xlate.sv
// Top of the mixed page-size translator: accepts a lookup when idle,
// answers hits from the store one cycle later, and hands misses to the
// walker whose result is installed and answered. Assumes the requester
// retries nothing itself; lookups during a walk are dropped.
module mpt_xlate
    import mpt_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int PA_W    = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [42:0]      req_va,
    input  logic [PA_W-1:0]  root_base,
    output logic             mem_rd_req,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [63:0]      mem_rd_data,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic             resp_fault,
    output logic [PA_W-1:0]  resp_pa,
    output logic             busy
);
    localparam int PFN_W = PA_W - PG_SHIFT;

    logic             lk_hit;
    logic [PA_W-1:0]  lk_pa;
    logic             accept;
    logic             walk_start;
    logic             hit_q;
    logic [PA_W-1:0]  hit_pa_q;
    logic             fill_en;
    logic [VPN_W-1:0] fill_vpn;
    logic             fill_huge;
    logic [PFN_W-1:0] fill_pfn;
    logic             w_done;
    logic             w_fault;
    logic [PA_W-1:0]  w_pa;

    assign accept     = req_valid && !busy;
    assign walk_start = accept && !lk_hit;

    mpt_tlb_array #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_va     (req_va),
        .lk_hit    (lk_hit),
        .lk_pa     (lk_pa),
        .fill_en   (fill_en),
        .fill_vpn  (fill_vpn),
        .fill_huge (fill_huge),
        .fill_pfn  (fill_pfn)
    );

    mpt_walker #(.PA_W(PA_W)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (walk_start),
        .start_va     (req_va),
        .root_base    (root_base),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .busy         (busy),
        .fill_en      (fill_en),
        .fill_vpn     (fill_vpn),
        .fill_huge    (fill_huge),
        .fill_pfn     (fill_pfn),
        .done         (w_done),
        .fault        (w_fault),
        .done_pa      (w_pa)
    );

    // Hit answer register: one cycle after an accepted hitting lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q    <= 1'b0;
            hit_pa_q <= '0;
        end else begin
            hit_q    <= accept && lk_hit;
            hit_pa_q <= lk_pa;
        end
    end

    assign resp_valid = hit_q || w_done;
    assign resp_hit   = hit_q;
    assign resp_fault = w_fault;
    assign resp_pa    = hit_q ? hit_pa_q : w_pa;

    // R1: reset leaves the block idle with no answer.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !resp_valid && !mem_rd_req));
    // R9: a hit answer and a walk answer never collide.
    a_r9_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_q && w_done));
    // R9: a missing lookup makes the block busy next cycle.
    a_r9_miss_busy: assert property (@(posedge clk) disable iff (!rst_n)
        walk_start |=> busy);
endmodule

// File: tb/mpt_xlate_bench.sv
// Scoreboard bench: lookup tasks queue expected answers, a monitor pops and
// compares them on falling edges; a latency-programmable table memory.
module mpt_xlate_bench;
    localparam int PA_W    = 40;
    localparam int ENTRIES = 4;
    localparam logic [39:0] ROOT = 40'h00_0010_0000;
    localparam logic [39:0] L2T  = 40'h00_0020_0000;
    localparam logic [39:0] L3T  = 40'h00_0030_0000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [42:0]      req_va = '0;
    logic [PA_W-1:0]  root_base = ROOT;
    logic             mem_rd_req;
    logic [PA_W-1:0]  mem_rd_addr;
    logic             mem_rd_valid = 1'b0;
    logic [63:0]      mem_rd_data = '0;
    logic             resp_valid, resp_hit, resp_fault, busy;
    logic [PA_W-1:0]  resp_pa;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int wait_cnt = 0;

    logic [63:0] pt_mem [logic [39:0]];
    logic [39:0] rd_log [$];
    int          q_kind [$];   // 0 hit, 1 walk fill, 2 fault
    logic [39:0] q_pa [$];
    string       q_tag [$];

    always #10 clk = ~clk;   // 20 time units per cycle: 50 MHz at 1 ns

    mpt_xlate #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_mpt_xlate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .root_base(root_base), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
        .resp_pa(resp_pa), .busy(busy));

    // Table memory: answers a held request after lat extra cycles.
    always @(posedge clk) begin
        if (mem_rd_req && !mem_rd_valid) begin
            if (wait_cnt >= lat) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= pt_mem.exists(mem_rd_addr) ? pt_mem[mem_rd_addr] : 64'd0;
                wait_cnt     <= 0;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end else begin
            mem_rd_valid <= 1'b0;
        end
    end

    // Read logger: records each completing handshake.
    always @(negedge clk) begin
        if (mem_rd_req && mem_rd_valid) rd_log.push_back(mem_rd_addr);
    end

    // Monitor: compares each answer with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            checks++;
            if (q_kind.size() == 0) begin
                errors++;
                $display("FAIL R9: unexpected answer pa=%h hit=%0b fault=%0b, expected none",
                         resp_pa, resp_hit, resp_fault);
            end else begin
                int k;
                int got;
                logic [39:0] p;
                string t;
                k = q_kind.pop_front();
                p = q_pa.pop_front();
                t = q_tag.pop_front();
                got = resp_fault ? 2 : (resp_hit ? 0 : 1);
                if (got != k || (k != 2 && resp_pa != p)) begin
                    errors++;
                    $display("FAIL %s: kind=%0d pa=%h, expected kind=%0d pa=%h", t, got, resp_pa, k, p);
                end
            end
        end
    end

    function automatic logic [42:0] mkva(input int l1, input int l2, input int l3, input int off);
        return {11'(l1), 11'(l2), 9'(l3), 12'(off)};
    endfunction

    function automatic logic [39:0] ea(input logic [39:0] base, input int idx);
        return base + 40'(idx) * 40'd8;
    endfunction

    task automatic check_reads(input string tag, input int n, input logic [39:0] a0,
                               input logic [39:0] a1, input logic [39:0] a2);
        logic [39:0] exp_a [3];
        exp_a[0] = a0; exp_a[1] = a1; exp_a[2] = a2;
        checks++;
        if (rd_log.size() != n) begin
            errors++;
            $display("FAIL %s: read count %0d, expected %0d", tag, rd_log.size(), n);
        end else begin
            for (int i = 0; i < n; i++) begin
                if (rd_log[i] != exp_a[i]) begin
                    errors++;
                    $display("FAIL %s: read %0d addr %h, expected %h", tag, i, rd_log[i], exp_a[i]);
                end
            end
        end
    endtask

    task automatic wait_answer();
        while (q_kind.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Driver: queue the expectation, present one lookup, check the walk reads.
    task automatic lookup(input logic [42:0] va, input int kind, input logic [39:0] pa,
                          input string tag, input int n, input logic [39:0] a0,
                          input logic [39:0] a1, input logic [39:0] a2);
        rd_log.delete();
        q_kind.push_back(kind); q_pa.push_back(pa); q_tag.push_back(tag);
        @(negedge clk);
        req_valid = 1'b1; req_va = va;
        @(negedge clk);
        req_valid = 1'b0;
        wait_answer();
        check_reads(tag, n, a0, a1, a2);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        pt_mem[ea(ROOT, 3)]  = {24'd0, L2T} | 64'h1;
        pt_mem[ea(L2T, 5)]   = {24'd0, L3T} | 64'h1;
        pt_mem[ea(L2T, 9)]   = 64'h12_3460_0003;       // 2 MB leaf
        pt_mem[ea(L3T, 7)]   = 64'hAB_CDE0_03;         // leaf bit ignored at level 3
        pt_mem[ea(L3T, 1)]   = 64'h1111_1001;
        pt_mem[ea(L3T, 2)]   = 64'h2222_2001;
        pt_mem[ea(L3T, 3)]   = 64'h3333_3001;

        repeat (3) @(negedge clk);
        // R1: idle outputs during and after reset
        checks++;
        if (busy || resp_valid || mem_rd_req) begin
            errors++;
            $display("FAIL R1: busy=%0b resp_valid=%0b req=%0b, expected 0 0 0", busy, resp_valid, mem_rd_req);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (busy || resp_valid || mem_rd_req) begin
            errors++;
            $display("FAIL R1: after reset busy=%0b resp_valid=%0b, expected 0 0", busy, resp_valid);
        end

        // R1 R4 R5 R6: first lookup walks three levels (slot 0)
        lookup(mkva(3, 5, 7, 12'h123), 1, 40'h00_ABCD_E123, "R4_R6_4k_walk", 3,
               ea(ROOT, 3), ea(L2T, 5), ea(L3T, 7));
        // R2: hit on the installed 4 KB page
        lookup(mkva(3, 5, 7, 12'hFFF), 0, 40'h00_ABCD_EFFF, "R2_4k_hit", 0, 0, 0, 0);
        // R5 R6: 2 MB leaf ends after two reads (slot 1)
        lookup({11'd3, 11'd9, 21'h1A_BCDE}, 1, 40'h12_347A_BCDE, "R5_R6_2m_walk", 2,
               ea(ROOT, 3), ea(L2T, 9), 0);
        // R3: other 4 KB sub-page of the same 2 MB region hits
        lookup({11'd3, 11'd9, 21'h00_0010}, 0, 40'h12_3460_0010, "R3_2m_hit", 0, 0, 0, 0);
        // R3 R7: neighbouring 2 MB region misses and faults at level 2
        lookup({11'd3, 11'd10, 21'h0}, 2, 0, "R3_R7_l2_fault", 2, ea(ROOT, 3), ea(L2T, 10), 0);
        // R7: level-1 fault, then again since nothing was installed
        lookup(mkva(6, 0, 0, 0), 2, 0, "R7_l1_fault", 1, ea(ROOT, 6), 0, 0);
        lookup(mkva(6, 0, 0, 0), 2, 0, "R7_l1_refault", 1, ea(ROOT, 6), 0, 0);
        // R7: level-3 fault after three reads
        lookup(mkva(3, 5, 8, 0), 2, 0, "R7_l3_fault", 3, ea(ROOT, 3), ea(L2T, 5), ea(L3T, 8));

        // R9 R10: slow memory; lookups presented while busy are ignored (slot 2)
        lat = 3;
        rd_log.delete();
        q_kind.push_back(1); q_pa.push_back(40'h00_1111_1044); q_tag.push_back("R10_slow_walk");
        @(negedge clk);
        req_valid = 1'b1; req_va = mkva(3, 5, 1, 12'h044);
        @(negedge clk);
        checks++;
        if (!busy) begin
            errors++;
            $display("FAIL R9: busy=%0b after miss, expected 1", busy);
        end
        req_va = mkva(3, 5, 7, 0);   // would hit if accepted
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        wait_answer();
        check_reads("R10_slow_walk", 3, ea(ROOT, 3), ea(L2T, 5), ea(L3T, 1));
        checks++;
        if (busy) begin
            errors++;
            $display("FAIL R9: busy=%0b after answer, expected 0", busy);
        end
        lat = 0;

        // R8: fill slot 3, then slot 0 wraps over the first page
        lookup(mkva(3, 5, 2, 12'h008), 1, 40'h00_2222_2008, "R8_fill3", 3, ea(ROOT, 3), ea(L2T, 5), ea(L3T, 2));
        lookup(mkva(3, 5, 3, 12'h000), 1, 40'h00_3333_3000, "R8_fill_wrap", 3, ea(ROOT, 3), ea(L2T, 5), ea(L3T, 3));
        lookup(mkva(3, 5, 1, 12'h010), 0, 40'h00_1111_1010, "R8_keep_slot2", 0, 0, 0, 0);
        lookup(mkva(3, 5, 2, 12'h000), 0, 40'h00_2222_2000, "R8_keep_slot3", 0, 0, 0, 0);
        lookup({11'd3, 11'd9, 21'h0}, 0, 40'h12_3460_0000, "R8_keep_slot1", 0, 0, 0, 0);
        // R8: oldest page was evicted; its refill replaces the 2 MB slot despite recent use
        lookup(mkva(3, 5, 7, 12'h001), 1, 40'h00_ABCD_E001, "R8_evicted_first", 3,
               ea(ROOT, 3), ea(L2T, 5), ea(L3T, 7));
        lookup({11'd3, 11'd9, 21'h5}, 1, 40'h12_3460_0005, "R8_fifo_not_lru", 2, ea(ROOT, 3), ea(L2T, 9), 0);
        lookup(mkva(3, 5, 3, 12'h001), 0, 40'h00_3333_3001, "R8_wrap_slot0", 0, 0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule